// File: doc/BRIEF.md
# Clock Phase Delay Codec

This block turns a requested clock phase, given in degrees, into the packed word that programs a sample-clock timing register. It also turns the word already stored in that register back into degrees. A phase is split into whole quarter cycles and a leftover angle. The leftover angle becomes a count of fixed 60 ps delay elements, scaled by the current card clock rate. The block holds the timing register itself. Every update reaches the register through a masked-halfword write: the upper sixteen bits say which of the lower sixteen bits may change.

A client raises `req_valid` together with an operation code while the block is idle. There are four operation codes. A phase write computes and applies a new setting. A readback decodes the stored register. A raw load applies a caller-supplied masked word directly. The fourth code is rejected. The divisions run on one shared restoring divider, so an operation can take several dozen cycles. `busy` is high during that time, and a one-cycle `done` pulse marks the moment the outputs become valid.

Top module: `phase_delay_codec`

## Requirements
- R1: On a phase write, the coarse field (packed bits 1:0, stored at register bits 2:1) equals the angle divided by 90.
- R2: The fine count (packed bits 9:2, stored at register bits 10:3) is the rounded-to-nearest quotient (r*10000000 + d*108) / (d*216), where r is the angle modulo 90 and d is the rate in Hz divided by 1000 and truncated. A remainder r of zero gives a count of zero.
- R3: The fine count saturates at 255. This includes any rate below 1000 Hz combined with a nonzero remainder.
- R4: Packed bit 10 (stored at register bit 11) is the fine-delay enable, and it is 1 exactly when the fine count is nonzero.
- R5: The write word `wr_word` carries the 11-bit packed value shifted left by one in its lower half, with bits 15:12 and bit 0 at zero. Its upper half is 0x0FFE.
- R6: Every write, whether a phase write or a raw load (op 2), changes only those register bits whose mask bit in the upper half of the word is set. All other bits keep their values.
- R7: A phase write with a rate of zero, or with an angle above 359, ends with `err` high. Both `tim_reg` and `wr_word` stay unchanged.
- R8: A readback (op 1) starts from coarse field register bits 2:1 times 90.
- R9: When register bit 11 is set, a readback adds round-to-nearest (n*216*(rate/10000) + 500000) / 1000000, where n is register bits 10:3. The result is then reduced modulo 360.
- R10: A readback with a rate of zero returns 0 degrees without error.
- R11: Requests are taken only while `busy` is low, and a request made while busy is ignored. Each accepted request produces exactly one `done` pulse lasting one cycle. Op code 3 ends with `err` high and changes nothing.
- R12: After reset, `tim_reg`, `wr_word`, `rd_deg`, `done`, `err` and `busy` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 2 | 0 phase write, 1 readback, 2 raw load, 3 rejected |
| req_rate | input | 32 | Card clock rate in Hz |
| req_angle | input | 9 | Requested phase in degrees |
| req_raw | input | 32 | Masked word for raw load |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation was rejected |
| wr_word | output | 32 | Last masked word applied to the register |
| rd_deg | output | 9 | Last readback result in degrees |
| tim_reg | output | 16 | Stored timing register |

## Verification
The bench targets several corner cases. Remainder-free angles must leave the enable bit clear; a design that skips that test would set bit 11 with a zero count. Slow rates and sub-kilohertz rates must saturate the count; a design without the clamp would wrap to a small value. On readback, the fine contribution can push the total well past 360 degrees; a design without the modulo step would report an impossible angle. Partially masked raw loads, rate-zero and out-of-range requests, and requests made during a busy period are also exercised: a wrong design would disturb the unmasked bits, overwrite the register on an error, or start a second operation.

// File: rtl/phase_delay_codec.sv
module phase_delay_codec #(
  parameter int RATE_W  = 32,
  parameter int ANG_W   = 9,
  parameter int DIV_W   = 36,
  parameter int ELEM_PS = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [RATE_W-1:0] req_rate,
  input  logic [ANG_W-1:0]  req_angle,
  input  logic [31:0]       req_raw,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       wr_word,
  output logic [ANG_W-1:0]  rd_deg,
  output logic [15:0]       tim_reg
);

  localparam int FINE_W   = 8;
  localparam int FINE_MAX = (1 << FINE_W) - 1;
  localparam int SCALE    = (ELEM_PS / 10) * 36;
  localparam int CW       = $clog2(DIV_W);
  localparam logic [CW-1:0] CLAST = CW'(DIV_W - 1);
  localparam logic [1:0] OP_SET = 2'd0, OP_GET = 2'd1, OP_RAW = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_WDIV, S_WFINE, S_RDIV, S_RSCL, S_RMOD} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [DIV_W-1:0]  dvd, dsr;
  logic [DIV_W:0]    rmd;
  logic [1:0]        coarse_q;
  logic [6:0]        rem_q;
  logic [FINE_W-1:0] fine_q;
  logic [ANG_W-1:0]  base_q;

  logic [DIV_W:0]   trial, rmd_n;
  logic             ge;
  logic [DIV_W-1:0] quot;

  assign trial = {rmd[DIV_W-1:0], dvd[DIV_W-1]};
  assign ge    = trial >= {1'b0, dsr};
  assign rmd_n = ge ? trial - {1'b0, dsr} : trial;
  assign quot  = {dvd[DIV_W-2:0], ge};
  assign busy  = st != S_IDLE;

  logic [1:0] ang_q;
  logic [6:0] ang_r;
  assign ang_q = 2'(req_angle / 90);
  assign ang_r = 7'(req_angle % 90);

  function automatic logic [31:0] pack(input logic [1:0] c, input logic [FINE_W-1:0] f);
    return {4'h0, 11'h7FF, 1'b0, 4'h0, (f != '0), f, c, 1'b0};
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] cur, input logic [31:0] w);
    return (cur & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; dvd <= '0; dsr <= '0; rmd <= '0;
      coarse_q <= '0; rem_q <= '0; fine_q <= '0; base_q <= '0;
      done <= 1'b0; err <= 1'b0; wr_word <= '0; rd_deg <= '0; tim_reg <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          err <= 1'b0;
          cnt <= '0;
          rmd <= '0;
          case (req_op)
            OP_SET: begin
              if (req_rate == '0 || req_angle > ANG_W'(359)) begin
                err <= 1'b1; done <= 1'b1;
              end else if (ang_r == '0) begin
                wr_word <= pack(ang_q, '0);
                tim_reg <= merge(tim_reg, pack(ang_q, '0));
                done <= 1'b1;
              end else begin
                coarse_q <= ang_q; rem_q <= ang_r;
                dvd <= DIV_W'(req_rate); dsr <= DIV_W'(1000);
                st <= S_WDIV;
              end
            end
            OP_GET: begin
              if (req_rate == '0) begin
                rd_deg <= '0; done <= 1'b1;
              end else if (!tim_reg[11]) begin
                rd_deg <= ANG_W'(tim_reg[2:1]) * ANG_W'(90); done <= 1'b1;
              end else begin
                base_q <= ANG_W'(tim_reg[2:1]) * ANG_W'(90);
                fine_q <= tim_reg[10:3];
                dvd <= DIV_W'(req_rate); dsr <= DIV_W'(10000);
                st <= S_RDIV;
              end
            end
            OP_RAW: begin
              wr_word <= req_raw;
              tim_reg <= merge(tim_reg, req_raw);
              done <= 1'b1;
            end
            default: begin
              err <= 1'b1; done <= 1'b1;
            end
          endcase
        end
      end else begin
        dvd <= quot;
        rmd <= rmd_n;
        cnt <= cnt + 1'b1;
        if (cnt == CLAST) begin
          cnt <= '0;
          rmd <= '0;
          case (st)
            S_WDIV: begin
              dvd <= DIV_W'(rem_q) * DIV_W'(10000000) + quot * DIV_W'(SCALE / 2);
              dsr <= quot * DIV_W'(SCALE);
              st  <= S_WFINE;
            end
            S_WFINE: begin
              wr_word <= pack(coarse_q, (quot > DIV_W'(FINE_MAX)) ? FINE_W'(FINE_MAX) : quot[FINE_W-1:0]);
              tim_reg <= merge(tim_reg, pack(coarse_q, (quot > DIV_W'(FINE_MAX)) ? FINE_W'(FINE_MAX) : quot[FINE_W-1:0]));
              done <= 1'b1;
              st   <= S_IDLE;
            end
            S_RDIV: begin
              dvd <= DIV_W'(fine_q) * DIV_W'(SCALE) * quot + DIV_W'(500000);
              dsr <= DIV_W'(1000000);
              st  <= S_RSCL;
            end
            S_RSCL: begin
              dvd <= DIV_W'(base_q) + quot;
              dsr <= DIV_W'(360);
              st  <= S_RMOD;
            end
            default: begin
              rd_deg <= ANG_W'(rmd_n[DIV_W-1:0]);
              done <= 1'b1;
              st   <= S_IDLE;
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/phase_delay_codec_chk.sv
module phase_delay_codec_chk #(
  parameter int ANG_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_op,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [31:0]      wr_word,
  input logic [ANG_W-1:0] rd_deg,
  input logic [15:0]      tim_reg
);

  logic [1:0] last_op;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_op <= 2'd0;
    else if (req_valid && !busy) last_op <= req_op;
  end

  logic set_ok;
  assign set_ok = done && !err && last_op == 2'd0;

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_deg_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_deg < ANG_W'(360));
  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (tim_reg == $past(tim_reg) && wr_word == $past(wr_word)));
  assert_word_layout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_ok |-> (wr_word[31:16] == 16'h0FFE && wr_word[15:12] == 4'h0 && !wr_word[0]));
  assert_enable_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_ok |-> (wr_word[11] == (wr_word[10:3] != 8'h00)));
  assert_unmasked_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_ok |-> (tim_reg[15:12] == $past(tim_reg[15:12]) && tim_reg[0] == $past(tim_reg[0])));

endmodule

bind phase_delay_codec phase_delay_codec_chk #(.ANG_W(ANG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .busy(busy), .done(done), .err(err), .wr_word(wr_word),
  .rd_deg(rd_deg), .tim_reg(tim_reg)
);

// File: tb/test_phase_delay_codec.sv
`timescale 1ns/1ps
module test_phase_delay_codec;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_rate = '0;
  logic [8:0]  req_angle = '0;
  logic [31:0] req_raw = '0;
  logic        busy, done, err;
  logic [31:0] wr_word;
  logic [8:0]  rd_deg;
  logic [15:0] tim_reg;

  always #2.5 clk = ~clk;

  phase_delay_codec i_phase_delay_codec (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_rate(req_rate), .req_angle(req_angle), .req_raw(req_raw),
    .busy(busy), .done(done), .err(err), .wr_word(wr_word),
    .rd_deg(rd_deg), .tim_reg(tim_reg)
  );

  int checks = 0, fails = 0;
  logic [15:0] m_reg = '0;

  localparam int NV = 12;
  localparam logic [31:0] RATES [NV] = '{32'd200000000, 32'd200000000, 32'd200000000, 32'd200000000,
                                         32'd50000000, 32'd400000, 32'd150000000, 32'd100000000,
                                         32'd500, 32'd25000000, 32'hFFFFFFFF, 32'd12345678};
  localparam logic [8:0]  ANGS  [NV] = '{9'd45, 9'd0, 9'd90, 9'd359, 9'd135, 9'd89, 9'd270, 9'd1,
                                         9'd30, 9'd200, 9'd10, 9'd77};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_count(input longint unsigned rate, input int ang);
    longint unsigned r, d, q;
    r = ang % 90;
    if (r == 0) return 8'd0;
    d = rate / 1000;
    if (d == 0) return 8'd255;
    q = (r * 10000000 + d * 108) / (d * 216);
    return (q > 255) ? 8'd255 : q[7:0];
  endfunction

  function automatic logic [31:0] m_word(input int ang, input logic [7:0] c);
    logic [1:0] co;
    co = 2'(ang / 90);
    return {4'h0, 11'h7FF, 1'b0, 4'h0, (c != 0), c, co, 1'b0};
  endfunction

  function automatic logic [15:0] m_merge(input logic [15:0] cur, input logic [31:0] w);
    return (cur & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  function automatic logic [8:0] m_read(input logic [15:0] r, input longint unsigned rate);
    longint unsigned deg;
    if (rate == 0) return 9'd0;
    deg = r[2:1] * 90;
    if (r[11]) deg += (longint'(r[10:3]) * 216 * (rate / 10000) + 500000) / 1000000;
    return 9'(deg % 360);
  endfunction

  task automatic run(input logic [1:0] op, input logic [31:0] rate, input logic [8:0] ang,
                     input logic [31:0] raw);
    int n;
    @(negedge clk);
    req_op = op; req_rate = rate; req_angle = ang; req_raw = raw; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    check("R11 done seen", {31'd0, done}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0]  c;
    logic [31:0] w;
    int ndone;
    repeat (3) @(negedge clk);
    check("R12 tim_reg", {16'd0, tim_reg}, 32'd0);
    check("R12 wr_word", wr_word, 32'd0);
    check("R12 rd_deg", {23'd0, rd_deg}, 32'd0);
    check("R12 flags", {29'd0, done, err, busy}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      c = m_count(RATES[i], ANGS[i]);
      w = m_word(ANGS[i], c);
      m_reg = m_merge(m_reg, w);
      run(2'd0, RATES[i], ANGS[i], '0);
      check("R1 coarse", {30'd0, wr_word[2:1]}, {30'd0, w[2:1]});
      check(c == 8'd255 ? "R3 saturated count" : "R2 fine count", {24'd0, wr_word[10:3]}, {24'd0, c});
      check("R4 enable", {31'd0, wr_word[11]}, {31'd0, w[11]});
      check("R5 word", wr_word, w);
      check("R6 register", {16'd0, tim_reg}, {16'd0, m_reg});
      run(2'd1, RATES[i], 9'd0, '0);
      check("R8 R9 readback", {23'd0, rd_deg}, {23'd0, m_read(m_reg, RATES[i])});
    end

    run(2'd2, '0, '0, 32'hFFFF_A5A5);
    m_reg = 16'hA5A5;
    check("R6 raw full", {16'd0, tim_reg}, 32'h0000A5A5);
    run(2'd2, '0, '0, 32'h0000_FFFF);
    check("R6 raw no mask", {16'd0, tim_reg}, 32'h0000A5A5);
    run(2'd2, '0, '0, 32'hF000_0000);
    m_reg = 16'h05A5;
    check("R6 raw partial", {16'd0, tim_reg}, {16'd0, m_reg});
    w = m_word(0, 8'd0);
    m_reg = m_merge(m_reg, w);
    run(2'd0, 32'd200000000, 9'd0, '0);
    check("R6 keep unmasked", {16'd0, tim_reg}, {16'd0, m_reg});
    check("R4 zero remainder", {31'd0, wr_word[11]}, 32'd0);

    w = wr_word;
    run(2'd0, 32'd0, 9'd45, '0);
    check("R7 rate zero err", {31'd0, err}, 32'd1);
    check("R7 rate zero reg", {16'd0, tim_reg}, {16'd0, m_reg});
    check("R7 rate zero word", wr_word, w);
    run(2'd0, 32'd200000000, 9'd360, '0);
    check("R7 angle err", {31'd0, err}, 32'd1);
    check("R7 angle reg", {16'd0, tim_reg}, {16'd0, m_reg});

    run(2'd2, '0, '0, 32'hFFFF_0FFE);
    m_reg = 16'h0FFE;
    run(2'd1, 32'd200000000, 9'd0, '0);
    check("R9 wrap modulo", {23'd0, rd_deg}, {23'd0, m_read(m_reg, 64'd200000000)});
    check("R9 wrap value", {23'd0, rd_deg}, 32'd292);
    run(2'd1, 32'd0, 9'd0, '0);
    check("R10 rate zero read", {23'd0, rd_deg}, 32'd0);
    check("R10 no err", {31'd0, err}, 32'd0);
    run(2'd3, 32'd200000000, 9'd10, '0);
    check("R11 bad op err", {31'd0, err}, 32'd1);
    check("R11 bad op reg", {16'd0, tim_reg}, {16'd0, m_reg});

    c = m_count(64'd200000000, 45);
    m_reg = m_merge(m_reg, m_word(45, c));
    @(negedge clk);
    req_op = 2'd0; req_rate = 32'd200000000; req_angle = 9'd45; req_valid = 1'b1;
    @(negedge clk);
    req_op = 2'd2; req_raw = 32'hFFFF_0000;
    check("R11 busy", {31'd0, busy}, 32'd1);
    ndone = 0;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (done) ndone++;
      @(negedge clk);
    end
    check("R11 one done", ndone, 32'd1);
    check("R11 busy request ignored", {16'd0, tim_reg}, {16'd0, m_reg});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule